// File: doc/BRIEF.md
# Trace-Driven Cache Tag Engine

This block replays a memory access trace through a set-associative cache directory and says, for every data access, whether it would hit, miss into a free line, or miss and push out the least recently used line. It keeps valid bits and tags only. There is no data array, no write policy and no backing memory. Operations arrive one at a time on a valid/ready handshake. Each operation carries a kind code and a byte address.

Instruction fetches are accepted and then dropped. Loads and stores each cost one lookup. A modify costs two lookups on the same address, and the input is stalled for one cycle while the second lookup runs. Every lookup produces one result beat one cycle after it is made. Three saturating counters track hits, misses (evicting or not) and evictions.

The set-index width, the associativity and the block-offset width are elaboration parameters. A synchronous clear empties the directory and zeroes the counters.

Top module: `trace_cache_dir`

## Requirements
- R1: The address is split from the bottom up: OFF_BITS offset bits, then SET_BITS set-index bits, with the tag in the remaining upper bits. An access only looks at and changes the set selected by its index bits.
- R2: A lookup is a hit, result code 1, only when a valid line in the selected set holds the address tag.
- R3: A miss in a set that still has an invalid line fills the lowest-numbered invalid line and reports result code 2, with no eviction.
- R4: A miss in a full set replaces the least recently used line of that set and reports result code 3. A hit or a fill makes a line the most recently used. With WAYS=1, any valid line whose tag differs is replaced.
- R5: Kind code 0 (instruction fetch) is accepted and ignored. It produces no result beat and changes no line and no counter.
- R6: Kind code 3 (modify) makes two lookups on one address. This gives the result pair miss-or-evict then hit, or hit then hit, on consecutive cycles. op_ready is low for the cycle after the modify is accepted.
- R7: Kind codes 1 (load) and 2 (store) are classified the same way, and both allocate a line on a miss.
- R8: hit_count counts code-1 beats. miss_count counts code-2 and code-3 beats. evict_count counts code-3 beats. Each counter is CNT_W bits wide and holds at 2^CNT_W-1 instead of wrapping.
- R9: A cycle with clear high invalidates every line, zeroes all counters and drops any pending second lookup.
- R10: With SET_BITS=4, WAYS=1, OFF_BITS=4, the sequence load 0x10, modify 0x20, load 0x22, store 0x18, load 0x110, load 0x210, modify 0x12 ends with 4 hits, 5 misses and 3 evictions.
- R11: The result beat (res_valid high) for a lookup appears in the cycle after the operation is accepted. For a modify, the second beat comes one cycle after the first.
- R12: After reset, op_ready is high, res_valid is low and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous invalidate-all and counter clear |
| op_valid | input | 1 | Operation offered |
| op_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 modify |
| op_addr | input | ADDR_W | Byte address of the access |
| op_ready | output | 1 | Operation can be accepted this cycle |
| res_valid | output | 1 | Result beat present |
| res_code | output | 2 | 1 hit, 2 miss, 3 miss with eviction |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |
| evict_count | output | CNT_W | Saturating eviction counter |

## Verification
The bench drives two instances and runs a timestamp-based LRU model alongside each. The four-way instance goes after victim choice once a set is full. If the design kept age order wrongly, it would evict a line that had just been touched, and a later access to that line would come back as an eviction instead of a hit. Fetches aimed at missing addresses check that a fetch allocates nothing: a design that let a fetch through would turn the next load into a hit. The direct-mapped instance runs the known seven-operation trace and then enough conflicting loads to push its narrow counters to saturation, where a wrapping counter would drop back to zero. A clear followed by a re-access catches valid bits that survive the clear.

// File: rtl/trace_cache_dir.sv
module trace_cache_dir #(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 2,
  parameter int WAYS     = 4,
  parameter int OFF_BITS = 4,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  output logic              op_ready,
  output logic              res_valid,
  output logic [1:0]        res_code,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  evict_count
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int TAG_W = ADDR_W - SET_BITS - OFF_BITS;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [WAY_W-1:0] MAX_AGE = WAY_W'(WAYS - 1);

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic             vld_q [SETS][WAYS];
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;

  assign op_ready = !pend_q && !clear;

  wire accept  = op_valid && op_ready;
  wire do_look = !clear && (pend_q || (accept && op_kind != 2'd0));

  wire [ADDR_W-1:0]   la  = pend_q ? pend_addr_q : op_addr;
  wire [SET_BITS-1:0] set = la[OFF_BITS +: SET_BITS];
  wire [TAG_W-1:0]    tag = la[ADDR_W-1 -: TAG_W];

  logic             hit, free;
  logic [WAY_W-1:0] hit_way, free_way, old_way, sel;
  logic [WAY_W-1:0] ref_age;
  logic [1:0]       code;

  always_comb begin
    hit = 1'b0; hit_way = '0;
    free = 1'b0; free_way = '0;
    old_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (vld_q[set][w] && tag_q[set][w] == tag) begin
        hit = 1'b1;
        hit_way = WAY_W'(w);
      end
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_q[set][w]) begin
        free = 1'b1;
        free_way = WAY_W'(w);
      end
    for (int w = 0; w < WAYS; w++)
      if (age_q[set][w] == MAX_AGE) old_way = WAY_W'(w);
    sel     = hit ? hit_way : (free ? free_way : old_way);
    ref_age = hit ? age_q[set][hit_way] : MAX_AGE;
    code    = hit ? 2'd1 : (free ? 2'd2 : 2'd3);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w] <= 1'b0;
          tag_q[s][w] <= '0;
          age_q[s][w] <= '0;
        end
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      res_valid   <= 1'b0;
      res_code    <= 2'd0;
      hit_count   <= '0;
      miss_count  <= '0;
      evict_count <= '0;
    end else begin
      res_valid <= do_look;
      if (do_look) begin
        res_code <= code;
        tag_q[set][sel] <= tag;
        vld_q[set][sel] <= 1'b1;
        for (int w = 0; w < WAYS; w++)
          if (WAY_W'(w) == sel) age_q[set][w] <= '0;
          else if (age_q[set][w] < ref_age) age_q[set][w] <= age_q[set][w] + 1'b1;
        if (hit && hit_count != '1) hit_count <= hit_count + 1'b1;
        if (!hit && miss_count != '1) miss_count <= miss_count + 1'b1;
        if (code == 2'd3 && evict_count != '1) evict_count <= evict_count + 1'b1;
      end
      if (pend_q) pend_q <= 1'b0;
      else if (accept && op_kind == 2'd3) begin
        pend_q      <= 1'b1;
        pend_addr_q <= op_addr;
      end
    end
  end
endmodule

// File: rtl/trace_cache_dir_chk.sv
module trace_cache_dir_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             op_valid,
  input logic             op_ready,
  input logic [1:0]       op_kind,
  input logic             res_valid,
  input logic [1:0]       res_code,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count,
  input logic [CNT_W-1:0] evict_count
);
  assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_code != 2'd0);

  assert_modify_stall_R6: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (op_valid && op_ready && op_kind == 2'd3) |=> !op_ready);

  assert_modify_second_hit_R6: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (op_valid && op_ready && op_kind == 2'd3) |=> ##1 (res_valid && res_code == 2'd1));

  assert_fetch_silent_R5: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (op_valid && op_ready && op_kind == 2'd0) |=> !res_valid);

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (op_valid && op_ready && op_kind != 2'd0) |=> res_valid);

  assert_hit_monotone_R8: assert property (@(posedge clk) disable iff (!rst_n || clear)
    1'b1 |=> hit_count >= $past(hit_count));

  assert_evict_le_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evict_count <= miss_count);

  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (hit_count == '0 && miss_count == '0 && evict_count == '0 && !res_valid));
endmodule

bind trace_cache_dir trace_cache_dir_chk #(.CNT_W(CNT_W)) chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .op_valid(op_valid), .op_ready(op_ready),
  .op_kind(op_kind), .res_valid(res_valid), .res_code(res_code),
  .hit_count(hit_count), .miss_count(miss_count), .evict_count(evict_count));

// File: tb/trace_cache_dir_test.sv
module trace_cache_dir_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        clr  [2];
  logic        v    [2];
  logic [1:0]  k    [2];
  logic [31:0] a    [2];
  logic        rdy  [2];
  logic        rv   [2];
  logic [1:0]  rc   [2];
  logic [31:0] hc   [2];
  logic [31:0] mc   [2];
  logic [31:0] ec   [2];
  logic [2:0]  hc1, mc1, ec1;

  trace_cache_dir uut (
    .clk(clk), .rst_n(rst_n), .clear(clr[0]), .op_valid(v[0]), .op_kind(k[0]), .op_addr(a[0]),
    .op_ready(rdy[0]), .res_valid(rv[0]), .res_code(rc[0]),
    .hit_count(hc[0]), .miss_count(mc[0]), .evict_count(ec[0]));

  trace_cache_dir #(.SET_BITS(4), .WAYS(1), .OFF_BITS(4), .CNT_W(3)) uut_dm (
    .clk(clk), .rst_n(rst_n), .clear(clr[1]), .op_valid(v[1]), .op_kind(k[1]), .op_addr(a[1]),
    .op_ready(rdy[1]), .res_valid(rv[1]), .res_code(rc[1]),
    .hit_count(hc1), .miss_count(mc1), .evict_count(ec1));

  assign hc[1] = {29'd0, hc1};
  assign mc[1] = {29'd0, mc1};
  assign ec[1] = {29'd0, ec1};

  int tests = 0, fails = 0, cyc = 0, stamp = 0;
  int mS[2], mE[2], mB[2], mmax[2];
  int mh[2], mm[2], mev[2];
  bit mv[2][128];
  longint mt[2][128];
  int mst[2][128];
  int ecode[2][$];
  int edue[2][$];
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int model_look(int m, int addr);
    int s, base, w, vic;
    longint tg;
    s = (addr >> mB[m]) & (mS[m] - 1);
    tg = longint'(addr) >> (mB[m] + $clog2(mS[m]));
    base = s * 8;
    stamp++;
    for (w = 0; w < mE[m]; w++)
      if (mv[m][base+w] && mt[m][base+w] == tg) begin
        mst[m][base+w] = stamp;
        return 1;
      end
    for (w = 0; w < mE[m]; w++)
      if (!mv[m][base+w]) begin
        mv[m][base+w] = 1'b1; mt[m][base+w] = tg; mst[m][base+w] = stamp;
        return 2;
      end
    vic = 0;
    for (w = 1; w < mE[m]; w++)
      if (mst[m][base+w] < mst[m][base+vic]) vic = w;
    mt[m][base+vic] = tg; mst[m][base+vic] = stamp;
    return 3;
  endfunction

  function automatic void model_clear(int m);
    for (int i = 0; i < 128; i++) mv[m][i] = 1'b0;
    mh[m] = 0; mm[m] = 0; mev[m] = 0;
  endfunction

  task automatic issue(input int m, input int kind, input int addr);
    @(negedge clk);
    v[m] = 1'b0;
    while (!rdy[m]) @(negedge clk);
    v[m] = 1'b1; k[m] = 2'(kind); a[m] = addr;
    if (kind != 0) begin
      ecode[m].push_back(model_look(m, addr)); edue[m].push_back(cyc + 1);
      if (kind == 3) begin
        ecode[m].push_back(model_look(m, addr)); edue[m].push_back(cyc + 2);
      end
    end
    @(posedge clk);
  endtask

  task automatic idle(input int m, input int n);
    @(negedge clk);
    v[m] = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear(input int m);
    idle(m, 3);
    clr[m] = 1'b1;
    model_clear(m);
    @(negedge clk);
    clr[m] = 1'b0;
    check(hc[m] == 0 && mc[m] == 0 && ec[m] == 0, "R9", "counters after clear", int'(hc[m] + mc[m] + ec[m]), 0);
    check(rv[m] == 1'b0, "R9", "no beat after clear", int'(rv[m]), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int m = 0; m < 2; m++) begin
        if (ecode[m].size() > 0 && edue[m][0] == cyc) begin
          int c;
          c = ecode[m].pop_front();
          void'(edue[m].pop_front());
          check(rv[m] == 1'b1, "R11", "beat present", int'(rv[m]), 1);
          check(int'(rc[m]) == c, (c == 1) ? "R2" : ((c == 2) ? "R3" : "R4"), "result code", int'(rc[m]), c);
          if (c == 1 && mh[m] < mmax[m]) mh[m]++;
          if (c != 1 && mm[m] < mmax[m]) mm[m]++;
          if (c == 3 && mev[m] < mmax[m]) mev[m]++;
          check(hc[m] == mh[m] && mc[m] == mm[m] && ec[m] == mev[m], "R8", "counters",
                int'(hc[m] * 1000000 + mc[m] * 1000 + ec[m]), mh[m] * 1000000 + mm[m] * 1000 + mev[m]);
        end else if (rv[m]) begin
          check(1'b0, "R5", "unexpected beat", 1, 0);
        end
      end
    end
  end

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "R11", "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    int seed, kind, addr;
    mS[0] = 4;  mE[0] = 4; mB[0] = 4; mmax[0] = -1 ^ (1 << 31);
    mS[1] = 16; mE[1] = 1; mB[1] = 4; mmax[1] = 7;
    for (int m = 0; m < 2; m++) begin
      clr[m] = 1'b0; v[m] = 1'b0; k[m] = 2'd0; a[m] = 0;
      model_clear(m);
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      check(rdy[m] == 1'b1 && rv[m] == 1'b0, "R12", "ready/valid after reset", int'({rdy[m], rv[m]}), 2);
      check(hc[m] == 0 && mc[m] == 0 && ec[m] == 0, "R12", "counters after reset", int'(hc[m] + mc[m] + ec[m]), 0);
    end

    // R10 known trace on the direct-mapped instance
    issue(1, 1, 'h10); issue(1, 3, 'h20); issue(1, 1, 'h22); issue(1, 2, 'h18);
    issue(1, 1, 'h110); issue(1, 1, 'h210); issue(1, 3, 'h12);
    idle(1, 4);
    check(hc[1] == 4, "R10", "hits", int'(hc[1]), 4);
    check(mc[1] == 5, "R10", "misses", int'(mc[1]), 5);
    check(ec[1] == 3, "R10", "evictions", int'(ec[1]), 3);
    // R8 saturation of the narrow counters
    for (int i = 0; i < 12; i++) issue(1, (i % 2) ? 2 : 1, (i % 2) ? 'h110 : 'h10);
    idle(1, 4);
    check(mc[1] == 7 && ec[1] == 7, "R8", "saturated miss/evict", int'(mc[1] * 10 + ec[1]), 77);
    do_clear(1);
    issue(1, 1, 'h10);
    idle(1, 3);
    check(mc[1] == 1 && hc[1] == 0, "R9", "line gone after clear", int'(mc[1]), 1);

    // R3/R4 fill then LRU on the four-way instance, set 0
    for (int t = 1; t <= 4; t++) issue(0, 1, t << 6);
    issue(0, 2, 1 << 6);
    issue(0, 1, 5 << 6);
    issue(0, 1, 1 << 6);
    issue(0, 1, 2 << 6);
    idle(0, 3);
    check(ec[0] == 2 && hc[0] == 2, "R4", "LRU evictions", int'(ec[0] * 10 + hc[0]), 22);
    // R1 other set untouched
    issue(0, 1, (1 << 6) | (1 << 4));
    issue(0, 1, 1 << 6);
    idle(0, 3);
    check(hc[0] == 3, "R1", "set 0 line survives set 1 fill", int'(hc[0]), 3);
    // R5 fetch allocates nothing
    issue(0, 0, 9 << 6);
    issue(0, 0, 9 << 6);
    idle(0, 3);
    check(mc[0] == 7, "R5", "fetch leaves counters", int'(mc[0]), 7);
    issue(0, 1, 9 << 6);
    idle(0, 3);
    check(ec[0] == 3, "R5", "fetched address still misses", int'(ec[0]), 3);
    // R6 modify on cold and warm addresses, R7 store allocates
    issue(0, 3, 'h2F0);
    issue(0, 3, 'h2F0);
    issue(0, 2, 'h3B0);
    issue(0, 1, 'h3B4);
    idle(0, 4);
    // mixed stress compared beat by beat
    seed = 7;
    for (int i = 0; i < 1500; i++) begin
      kind = $urandom(seed) % 4;
      seed = seed + 1;
      addr = (($urandom(seed) % 7) << 6) | (($urandom(seed + 3) % 4) << 4) | ($urandom(seed + 5) % 16);
      issue(0, kind, addr);
      if (i == 800) do_clear(0);
    end
    idle(0, 5);
    check(ecode[0].size() == 0 && ecode[1].size() == 0, "R11", "all beats seen",
          ecode[0].size() + ecode[1].size(), 0);
    summary();
  end
endmodule